// File: doc/BRIEF.md
# Gap-Modulated Tag Downlink Encoder

This block sends commands from a low-frequency reader to a passive tag by switching the reader field on and off. Each command bit is carried by the length of a field-on interval. A fixed field-off gap follows every bit. All timing is counted in field clocks: one `fcTick` pulse per carrier period, which is 8 us at 125 kHz.

A host presents a command descriptor and pulses `cmdStart` while the block is idle. The descriptor holds the operation, page bit, password enable, password, write data and block address. The block opens with a start gap, then sends the frame for that operation. After the frame it holds the field on, then ends with a one-cycle `captureStart` pulse (reset and read operations) or a `done` pulse (write and wake-up). Receive demodulation, the analog front end and host parsing sit outside this block.

Top module: `gap_downlink_enc`

## Requirements
- R1: One cycle after `cmdStart` is accepted, `busy` is 1 and `fieldOn` is 0. The field stays off for START_GAP (31) field clocks before the first bit.
- R2: Each bit is sent as `fieldOn`=1 for ZERO_ON (18) field clocks for a 0, or ONE_ON (50) field clocks for a 1. After every bit, `fieldOn`=0 for BIT_GAP (20) field clocks.
- R3: `cmdOp` 0 (reset) sends exactly the two bits 0,0. Codes 5, 6 and 7 are handled as reset.
- R4: `cmdOp` 1 (read) sends 1, then `cmdPage`, then the password MSB first (only when `cmdPwdEn`=1), then a 0 separator bit, then `cmdAddr` MSB first.
- R5: `cmdOp` 2 (register read) sends the same frame as a read but leaves out the address.
- R6: `cmdOp` 3 (write) sends 1, `cmdPage`, the optional password, a 0 lock bit, `cmdData` MSB first, then `cmdAddr` MSB first. The field is then held on for PROG_HOLD field clocks and switched off, `done` pulses, and the field stays off.
- R7: `cmdOp` 4 (wake-up) always sends 1, 0 and then the password MSB first, whatever `cmdPage` and `cmdPwdEn` are. The field is then held on for PROG_HOLD field clocks, `done` pulses, and the field stays on.
- R8: After a reset, read or register-read frame, the field is held on for READ_HOLD (52) field clocks. `captureStart` then pulses for one cycle and the field stays on while idle.
- R9: A command is accepted only while `busy` is 0. A `cmdStart` while busy has no effect on the frame being sent. `busy` falls in the same cycle as the end pulse.
- R10: After reset, `fieldOn`, `busy`, `captureStart` and `done` are all 0.
- R11: While busy, `fieldOn` changes only in the cycle after a cycle in which `fcTick` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fcTick | input | 1 | One-cycle pulse per field clock |
| cmdStart | input | 1 | Request to start a command (taken only when idle) |
| cmdOp | input | 3 | Operation: 0 reset, 1 read, 2 register read, 3 write, 4 wake-up, 5-7 reset |
| cmdPage | input | 1 | Page select bit |
| cmdPwdEn | input | 1 | Send the password after the opcode |
| cmdPwd | input | PWD_W (32) | Password |
| cmdData | input | DATA_W (32) | Write data |
| cmdAddr | input | ADDR_W (3) | Block address |
| busy | output | 1 | Command in progress |
| fieldOn | output | 1 | Reader field enable |
| captureStart | output | 1 | One-cycle pulse: start receive capture |
| done | output | 1 | One-cycle pulse: write or wake-up finished |

## Verification
The bench keeps the stated bit, gap, start and read-hold timings at their default values. It shortens PROG_HOLD to 40 field clocks, which keeps every write and wake-up run short and still distinct from the 52-clock read hold. `fcTick` fires on one cycle in three, so the rule that timing advances only on ticks is actually exercised. With these values the bench can sweep every `cmdOp` code, every address and both password settings, and it decodes each frame back from the measured field-on lengths.

// File: rtl/gap_dl_pkg.sv
package gap_dl_pkg;

  typedef enum logic [2:0] {
    OP_RESET   = 3'd0,
    OP_READ    = 3'd1,
    OP_REGREAD = 3'd2,
    OP_WRITE   = 3'd3,
    OP_WAKE    = 3'd4
  } opKind_e;

  typedef enum logic [1:0] {
    TAIL_CAPTURE = 2'd0,
    TAIL_PROG_OFF = 2'd1,
    TAIL_PROG_ON = 2'd2
  } tailKind_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_BITON  = 3'd2,
    ST_BITOFF = 3'd3,
    ST_TAIL   = 3'd4
  } phase_e;

  typedef struct packed {
    logic load;
    logic shift;
    logic cntClr;
  } dpCtl_t;

  function automatic opKind_e decodeOp(input logic [2:0] code);
    case (code)
      3'd1: return OP_READ;
      3'd2: return OP_REGREAD;
      3'd3: return OP_WRITE;
      3'd4: return OP_WAKE;
      default: return OP_RESET;
    endcase
  endfunction

endpackage

// File: rtl/gap_dl_datapath.sv
module gap_dl_datapath
  import gap_dl_pkg::*;
#(
  parameter int PWD_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 12,
  localparam int FRAME_W = 3 + PWD_W + DATA_W + ADDR_W,
  localparam int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              fcTick,
  input  logic [2:0]        cmdOp,
  input  logic              cmdPage,
  input  logic              cmdPwdEn,
  input  logic [PWD_W-1:0]  cmdPwd,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              curBit,
  output logic              lastBit,
  output logic [CNT_W-1:0]  tickCnt,
  output tailKind_e         tailKind
);

  logic [FRAME_W-1:0] frameReg;
  logic [LEN_W-1:0]   bitsLeft;
  tailKind_e          tailReg;

  logic [FRAME_W-1:0] acc;
  logic [FRAME_W-1:0] accAligned;
  int                 accLen;
  tailKind_e          tailNext;
  opKind_e            opSel;

  // Append the low n bits of v below the bits already collected.
  function automatic logic [FRAME_W-1:0] app(input logic [FRAME_W-1:0] a,
                                             input logic [FRAME_W-1:0] v,
                                             input int n);
    logic [FRAME_W-1:0] keep;
    keep = v & ~({FRAME_W{1'b1}} << n);
    return (a << n) | keep;
  endfunction

  always_comb begin
    opSel    = decodeOp(cmdOp);
    acc      = '0;
    accLen   = 0;
    tailNext = TAIL_CAPTURE;
    case (opSel)
      OP_READ, OP_REGREAD, OP_WRITE: begin
        acc    = app(acc, FRAME_W'({1'b1, cmdPage}), 2);
        accLen = 2;
        if (cmdPwdEn) begin
          acc    = app(acc, FRAME_W'(cmdPwd), PWD_W);
          accLen = accLen + PWD_W;
        end
        acc    = app(acc, '0, 1);
        accLen = accLen + 1;
        if (opSel == OP_WRITE) begin
          acc      = app(acc, FRAME_W'(cmdData), DATA_W);
          accLen   = accLen + DATA_W;
          tailNext = TAIL_PROG_OFF;
        end
        if (opSel != OP_REGREAD) begin
          acc    = app(acc, FRAME_W'(cmdAddr), ADDR_W);
          accLen = accLen + ADDR_W;
        end
      end
      OP_WAKE: begin
        acc      = app(acc, FRAME_W'(2'b10), 2);
        acc      = app(acc, FRAME_W'(cmdPwd), PWD_W);
        accLen   = 2 + PWD_W;
        tailNext = TAIL_PROG_ON;
      end
      default: begin
        acc    = '0;
        accLen = 2;
      end
    endcase
    accAligned = acc << (FRAME_W - accLen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '0;
      bitsLeft <= '0;
      tailReg  <= TAIL_CAPTURE;
    end else if (ctl.load) begin
      frameReg <= accAligned;
      bitsLeft <= LEN_W'(accLen);
      tailReg  <= tailNext;
    end else if (ctl.shift) begin
      frameReg <= frameReg << 1;
      bitsLeft <= bitsLeft - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           tickCnt <= '0;
    else if (ctl.cntClr) tickCnt <= '0;
    else if (fcTick)     tickCnt <= tickCnt + 1'b1;
  end

  assign curBit   = frameReg[FRAME_W-1];
  assign lastBit  = (bitsLeft == LEN_W'(1));
  assign tailKind = tailReg;

endmodule

// File: rtl/gap_dl_control.sv
module gap_dl_control
  import gap_dl_pkg::*;
#(
  parameter int START_GAP = 31,
  parameter int ZERO_ON   = 18,
  parameter int ONE_ON    = 50,
  parameter int BIT_GAP   = 20,
  parameter int READ_HOLD = 52,
  parameter int PROG_HOLD = 2500,
  parameter int CNT_W     = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fcTick,
  input  logic             cmdStart,
  input  logic             curBit,
  input  logic             lastBit,
  input  logic [CNT_W-1:0] tickCnt,
  input  tailKind_e        tailKind,
  output dpCtl_t           ctl,
  output logic             busy,
  output logic             fieldOn,
  output logic             captureStart,
  output logic             done
);

  phase_e state, stateNext;
  logic   idleField;
  int     target;
  logic   phaseEnd;
  logic   tailEnd;

  always_comb begin
    case (state)
      ST_BITON:  target = curBit ? ONE_ON : ZERO_ON;
      ST_BITOFF: target = BIT_GAP;
      ST_TAIL:   target = (tailKind == TAIL_CAPTURE) ? READ_HOLD : PROG_HOLD;
      default:   target = START_GAP;
    endcase
  end

  assign phaseEnd = fcTick && (tickCnt == CNT_W'(target - 1));
  assign tailEnd  = (state == ST_TAIL) && phaseEnd;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    case (state)
      ST_IDLE: if (cmdStart) begin
        ctl.load   = 1'b1;
        ctl.cntClr = 1'b1;
        stateNext  = ST_START;
      end
      ST_START: if (phaseEnd) begin
        ctl.cntClr = 1'b1;
        stateNext  = ST_BITON;
      end
      ST_BITON: if (phaseEnd) begin
        ctl.cntClr = 1'b1;
        stateNext  = ST_BITOFF;
      end
      ST_BITOFF: if (phaseEnd) begin
        ctl.cntClr = 1'b1;
        if (lastBit) stateNext = ST_TAIL;
        else begin
          ctl.shift = 1'b1;
          stateNext = ST_BITON;
        end
      end
      ST_TAIL: if (phaseEnd) begin
        ctl.cntClr = 1'b1;
        stateNext  = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      idleField    <= 1'b0;
      captureStart <= 1'b0;
      done         <= 1'b0;
    end else begin
      state        <= stateNext;
      captureStart <= tailEnd && (tailKind == TAIL_CAPTURE);
      done         <= tailEnd && (tailKind != TAIL_CAPTURE);
      if (tailEnd) idleField <= (tailKind != TAIL_PROG_OFF);
    end
  end

  always_comb begin
    case (state)
      ST_IDLE:  fieldOn = idleField;
      ST_BITON, ST_TAIL: fieldOn = 1'b1;
      default:  fieldOn = 1'b0;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/gap_downlink_enc.sv
module gap_downlink_enc
  import gap_dl_pkg::*;
#(
  parameter int PWD_W     = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3,
  parameter int START_GAP = 31,
  parameter int ZERO_ON   = 18,
  parameter int ONE_ON    = 50,
  parameter int BIT_GAP   = 20,
  parameter int READ_HOLD = 52,
  parameter int PROG_HOLD = 2500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fcTick,
  input  logic              cmdStart,
  input  logic [2:0]        cmdOp,
  input  logic              cmdPage,
  input  logic              cmdPwdEn,
  input  logic [PWD_W-1:0]  cmdPwd,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              busy,
  output logic              fieldOn,
  output logic              captureStart,
  output logic              done
);

  localparam int MAX_A = (START_GAP > ONE_ON) ? START_GAP : ONE_ON;
  localparam int MAX_B = (READ_HOLD > PROG_HOLD) ? READ_HOLD : PROG_HOLD;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_T = (MAX_C > BIT_GAP) ? MAX_C : BIT_GAP;
  localparam int CNT_W = $clog2(MAX_T + 1);

  dpCtl_t           ctl;
  logic             curBit;
  logic             lastBit;
  logic [CNT_W-1:0] tickCnt;
  tailKind_e        tailKind;

  gap_dl_datapath #(
    .PWD_W(PWD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .fcTick(fcTick),
    .cmdOp(cmdOp), .cmdPage(cmdPage), .cmdPwdEn(cmdPwdEn),
    .cmdPwd(cmdPwd), .cmdData(cmdData), .cmdAddr(cmdAddr),
    .curBit(curBit), .lastBit(lastBit), .tickCnt(tickCnt),
    .tailKind(tailKind)
  );

  gap_dl_control #(
    .START_GAP(START_GAP), .ZERO_ON(ZERO_ON), .ONE_ON(ONE_ON),
    .BIT_GAP(BIT_GAP), .READ_HOLD(READ_HOLD), .PROG_HOLD(PROG_HOLD),
    .CNT_W(CNT_W)
  ) u_control (
    .clk(clk), .rstN(rstN), .fcTick(fcTick), .cmdStart(cmdStart),
    .curBit(curBit), .lastBit(lastBit), .tickCnt(tickCnt),
    .tailKind(tailKind), .ctl(ctl), .busy(busy), .fieldOn(fieldOn),
    .captureStart(captureStart), .done(done)
  );

endmodule

// File: rtl/gap_dl_checker.sv
module gap_dl_checker (
  input logic clk,
  input logic rstN,
  input logic fcTick,
  input logic cmdStart,
  input logic busy,
  input logic fieldOn,
  input logic captureStart,
  input logic done
);

  AST_START_GAP_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !fieldOn); // R1

  AST_ACCEPT_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdStart)); // R9

  AST_END_WITH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (captureStart || done)); // R9

  AST_PULSE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (captureStart || done) |-> !busy); // R9

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({captureStart, done})); // R8

  AST_CAPTURE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    captureStart |=> !captureStart); // R8

  AST_CAPTURE_FIELD_ON: assert property (@(posedge clk) disable iff (!rstN)
    captureStart |-> fieldOn); // R8

  AST_FIELD_ON_TICK_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$past(fcTick)) |-> $stable(fieldOn)); // R11

endmodule

bind gap_downlink_enc gap_dl_checker u_gap_dl_checker (
  .clk(clk), .rstN(rstN), .fcTick(fcTick), .cmdStart(cmdStart),
  .busy(busy), .fieldOn(fieldOn), .captureStart(captureStart), .done(done)
);

// File: tb/gap_downlink_enc_bench.sv
module gap_downlink_enc_bench;

  localparam int START_GAP = 31;
  localparam int ZERO_ON   = 18;
  localparam int ONE_ON    = 50;
  localparam int BIT_GAP   = 20;
  localparam int READ_HOLD = 52;
  localparam int PROG_HOLD = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fcTick = 1'b0;
  logic        cmdStart = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic        cmdPage = 1'b0;
  logic        cmdPwdEn = 1'b0;
  logic [31:0] cmdPwd = '0;
  logic [31:0] cmdData = '0;
  logic [2:0]  cmdAddr = '0;
  logic        busy, fieldOn, captureStart, done;

  int totalChecks = 0;
  int failChecks  = 0;

  gap_downlink_enc #(
    .PROG_HOLD(PROG_HOLD)
  ) u_gap_downlink_enc (
    .clk(clk), .rstN(rstN), .fcTick(fcTick), .cmdStart(cmdStart),
    .cmdOp(cmdOp), .cmdPage(cmdPage), .cmdPwdEn(cmdPwdEn), .cmdPwd(cmdPwd),
    .cmdData(cmdData), .cmdAddr(cmdAddr), .busy(busy), .fieldOn(fieldOn),
    .captureStart(captureStart), .done(done)
  );

  always #4 clk = ~clk;

  initial begin
    int tdiv;
    tdiv = 0;
    forever begin
      @(negedge clk);
      tdiv = (tdiv + 1) % 3;
      fcTick = (tdiv == 0);
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    totalChecks++;
    if (!ok) begin
      failChecks++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failChecks++;
    totalChecks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  end

  logic expBits[0:99];
  int   expLen;

  task automatic expPush(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      expBits[expLen] = v[i];
      expLen++;
    end
  endtask

  // Builds the expected frame straight from the requirement text.
  task automatic buildExp(input int op, input logic pg, input logic pe,
                          input logic [31:0] pw, input logic [31:0] dt,
                          input logic [2:0] ad);
    expLen = 0;
    if (op == 1 || op == 2 || op == 3) begin
      expPush({31'd0, 1'b1}, 1);
      expPush({31'd0, pg}, 1);
      if (pe) expPush(pw, 32);
      expPush(32'd0, 1);
      if (op == 3) expPush(dt, 32);
      if (op != 2) expPush({29'd0, ad}, 3);
    end else if (op == 4) begin
      expPush(32'd2, 2);
      expPush(pw, 32);
    end else begin
      expPush(32'd0, 2);
    end
  endtask

  int   runLen[0:199];
  logic runLvl[0:199];

  task automatic runCmd(input int op, input logic pg, input logic pe,
                        input logic [31:0] pw, input logic [31:0] dt,
                        input logic [2:0] ad, input string tag,
                        input int injectAt);
    int nRuns, iter, expTail, nBits, badGap, badBit, firstBad, actBit;
    logic firstBusy, firstField, prevField, prevTick, glitch, sawCap, sawDone;
    logic endBusy, expIdleField;
    buildExp(op, pg, pe, pw, dt, ad);
    @(negedge clk);
    cmdOp = 3'(op); cmdPage = pg; cmdPwdEn = pe; cmdPwd = pw;
    cmdData = dt; cmdAddr = ad; cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    #1;
    firstBusy = busy; firstField = fieldOn;
    nRuns = 0; iter = 0; glitch = 1'b0; sawCap = 1'b0; sawDone = 1'b0;
    prevField = fieldOn; prevTick = 1'b0; endBusy = 1'b1;
    forever begin
      if (captureStart || done) begin
        sawCap = captureStart; sawDone = done; endBusy = busy;
        break;
      end
      if (iter > 0 && fieldOn != prevField && !prevTick) glitch = 1'b1;
      if (fcTick && nRuns < 200) begin
        if (nRuns == 0 || runLvl[nRuns-1] != fieldOn) begin
          runLvl[nRuns] = fieldOn; runLen[nRuns] = 1; nRuns++;
        end else runLen[nRuns-1]++;
      end
      prevField = fieldOn; prevTick = fcTick;
      if (injectAt > 0 && iter == injectAt) begin
        cmdOp = 3'd3; cmdData = 32'hFFFF_FFFF; cmdStart = 1'b1;
      end else cmdStart = 1'b0;
      iter++;
      if (iter > 40000) break;
      @(negedge clk); #1;
    end
    cmdStart = 1'b0;
    check(sawCap || sawDone, {tag, " R9 command ends with a pulse"}, iter, 0);
    check(firstBusy == 1'b1 && firstField == 1'b0, "R1 busy and field off after accept",
          {firstBusy, firstField}, 2);
    check(nRuns > 0 && runLvl[0] == 1'b0 && runLen[0] == START_GAP, "R1 start gap length",
          (nRuns > 0) ? runLen[0] : -1, START_GAP);
    check(nRuns == 2 + 2 * expLen, {tag, " frame bit count"}, (nRuns - 2) / 2, expLen);
    nBits = (nRuns - 2) / 2;
    if (nBits > expLen) nBits = expLen;
    badGap = 0; badBit = 0; firstBad = -1; actBit = 0;
    for (int b = 0; b < nBits; b++) begin
      if (runLen[2 + 2*b] != BIT_GAP) badGap++;
      if (runLen[1 + 2*b] == ONE_ON) actBit = 1;
      else if (runLen[1 + 2*b] == ZERO_ON) actBit = 0;
      else begin badBit++; actBit = -1; end
      if (actBit != int'(expBits[b]) && firstBad < 0) firstBad = b;
    end
    check(badGap == 0, "R2 gap after every bit", badGap, 0);
    check(badBit == 0, "R2 on-interval is ZERO_ON or ONE_ON", badBit, 0);
    check(firstBad < 0, {tag, " frame content (first bad bit index)"}, firstBad, -1);
    expTail = (op == 3 || op == 4) ? PROG_HOLD : READ_HOLD;
    check(nRuns > 1 && runLvl[nRuns-1] == 1'b1 && runLen[nRuns-1] == expTail,
          (op == 3) ? "R6 programming hold" : (op == 4) ? "R7 wake hold" : "R8 read hold",
          (nRuns > 0) ? runLen[nRuns-1] : -1, expTail);
    check(sawCap == (op != 3 && op != 4) && sawDone == (op == 3 || op == 4),
          "R8 end pulse kind", {sawCap, sawDone}, (op == 3 || op == 4) ? 1 : 2);
    check(endBusy == 1'b0, "R9 busy falls with end pulse", endBusy, 0);
    check(!glitch, "R11 field changes only after a tick", glitch, 0);
    expIdleField = (op != 3);
    @(negedge clk); #1;
    check(!captureStart && !done, "R8 end pulse lasts one cycle", {captureStart, done}, 0);
    repeat (5) @(negedge clk);
    #1;
    check(fieldOn == expIdleField && !busy,
          (op == 3) ? "R6 field off after write" : "R8 field held on after end",
          fieldOn, expIdleField);
  endtask

  initial begin
    #1;
    check(fieldOn == 1'b0 && busy == 1'b0 && !captureStart && !done,
          "R10 reset outputs", {fieldOn, busy, captureStart, done}, 0);
    repeat (3) @(negedge clk);
    check(fieldOn == 1'b0 && busy == 1'b0, "R10 idle after reset", {fieldOn, busy}, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R3: every reset-like code, with other fields varied
    for (int c = 0; c < 8; c++) begin
      if (c == 0 || c >= 5)
        runCmd(c, c[0], c[1], 32'hA5A5_0000 + 32'(c), 32'h1234_5678, 3'(c), "R3", 0);
    end
    // R4: read sweep over every address, both pages
    for (int a = 0; a < 8; a++)
      runCmd(1, a[0], 1'b0, 32'h0, 32'h0, 3'(a), "R4", 0);
    runCmd(1, 1'b1, 1'b1, 32'h8000_0001, 32'h0, 3'd5, "R4", 0);
    // R5: register read with and without password
    runCmd(2, 1'b0, 1'b0, 32'h0, 32'h0, 3'd7, "R5", 0);
    runCmd(2, 1'b1, 1'b1, 32'hC3C3_5A5A, 32'h0, 3'd2, "R5", 0);
    // R6: write with and without password
    runCmd(3, 1'b0, 1'b0, 32'h0, 32'hDEAD_BEEF, 3'd6, "R6", 0);
    runCmd(3, 1'b1, 1'b1, 32'h0F0F_F0F0, 32'h8000_0001, 3'd1, "R6", 0);
    // R7: wake-up ignores page and password enable
    runCmd(4, 1'b1, 1'b0, 32'h1357_9BDF, 32'h0, 3'd3, "R7", 0);
    // R9: a start request mid-frame must not disturb the read in progress
    runCmd(1, 1'b0, 1'b1, 32'h2468_ACE0, 32'h0, 3'd4, "R9", 300);
    $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  end

endmodule